// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is a memory-mapped controller for 32 general-purpose pins grouped as four 8-bit ports (A, B, C, D). A simple 32-bit register bus (write strobe, byte address, write data, combinational read data) sets which pins act as GPIO rather than as an alternate function, which GPIO pins drive their pads, and the value they drive. Reads of the data register return the pad levels after a two-flop synchronizer.

Each pin can raise an interrupt on a rising edge, a falling edge, or both. Detected edges latch into a write-one-to-clear status register. Two enable registers pick which pending pins reach each of two processor-core interrupt lines. Inside every per-pin register, port A takes the low byte and port D the high byte, but within each byte pin 0 sits at the most significant bit. The edge-select registers hold two bits per pin, packed as two 16-bit halves with the first port of each pair in the upper half.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, pad_oe and gpio_sel are all 0, and both interrupt lines are low.
- R2: Word offsets: 0x00 pin-function select, 0x04 alternate-select (storage only), 0x08 direction, 0x0C data, 0x10 status, 0x14 edge select ports A/B, 0x18 edge select ports C/D, 0x38 core-0 enable, 0x3C core-1 enable. In every per-pin register, logical pin p (port p/8, pin n = p%8) sits at word bit 8*(p/8)+7-n. Ports of the pad vectors use logical order (bit p is pin p).
- R3: gpio_sel[p] follows the pin-function bit (1 = GPIO, 0 = alternate). pad_oe[p] is 1 only when the pin is GPIO and its direction bit is 1.
- R4: A direction bit of 1 makes a pin an output, 0 an input. Writing the data register sets pad_out for every pin.
- R5: Reading the data register returns the pad levels through a two-stage synchronizer: a pad change becomes visible after the second rising clock edge, not after the first.
- R6: In 0x14, port A occupies bits 31:16 and port B bits 15:0. In 0x18, port C occupies 31:16 and port D 15:0. Within a half, pin n uses bit 15-2n for rising and bit 14-2n for falling.
- R7: A selected edge on a pin configured as a GPIO input sets its status bit on the third rising clock edge after the pad change. Both edges are detected when both bits are set. Output pins and alternate-function pins never set status.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An edge in the same cycle as its clear wins.
- R9: Each core interrupt line is the OR over pins of status AND that core's enable bit. Status latches regardless of the enables.
- R10: The alternate-select register reads back what was written and affects no output. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pad input levels, logical pin order |
| pad_out | output | 32 | Output values, logical pin order |
| pad_oe | output | 32 | Output enables, logical pin order |
| gpio_sel | output | 32 | 1 = pin under GPIO control, 0 = alternate function |
| irq_core0 | output | 1 | Interrupt line to core 0 |
| irq_core1 | output | 1 | Interrupt line to core 1 |

## Verification
The bench aims at the bit layout: it places single pins at the ends of ports and of words. A design that left pins LSB-first inside a byte, or swapped the two halves of an edge-select register, would light the wrong gpio_sel bit or record an edge on a different pin. It samples status exactly two and three edges after a pad change, so an extra or missing synchronizer stage shows up as an early or late flag. It also toggles output pins and alternate-function pins, and drives edges of the direction that is not selected. A detector that ignored direction, pin function or edge polarity would then set status bits that must stay clear. Interrupt routing is checked with enables on other pins, and write-zero is checked against write-one clearing, so wrong gating or a plain-write status register would be exposed.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int NPORT  = 4;
    localparam int PORT_W = 8;
    localparam int NPIN   = NPORT * PORT_W;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int HALF_W = 2 * PORT_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [AW-3:0] {
        W_FUNC  = 6'h00,
        W_ALT   = 6'h01,
        W_DIR   = 6'h02,
        W_DATA  = 6'h03,
        W_STAT  = 6'h04,
        W_EDGAB = 6'h05,
        W_EDGCD = 6'h06,
        W_IEN0  = 6'h0E,
        W_IEN1  = 6'h0F
    } word_idx_t;

    typedef struct packed {
        logic [NPIN-1:0] rise;
        logic [NPIN-1:0] fall;
    } edge_cfg_t;

    typedef struct packed {
        logic [NPIN-1:0] func;
        logic [NPIN-1:0] alt;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] ien0;
        logic [NPIN-1:0] ien1;
        edge_cfg_t       edg;
    } gpio_cfg_t;

    // Logical pin order <-> register word order. The permutation is its own inverse.
    function automatic logic [DW-1:0] swizzle(input logic [NPIN-1:0] v);
        logic [DW-1:0] w;
        w = '0;
        for (int p = 0; p < NPIN; p++)
            w[(p / PORT_W) * PORT_W + (PORT_W - 1 - (p % PORT_W))] = v[p];
        return w;
    endfunction

    // Pack the edge selects of ports base and base+1 into one word.
    function automatic logic [DW-1:0] edge_pack(input edge_cfg_t e, input int base);
        logic [DW-1:0] w;
        w = '0;
        for (int h = 0; h < 2; h++)
            for (int n = 0; n < PORT_W; n++) begin
                w[DW - 1 - h*HALF_W - 2*n] = e.rise[(base + h) * PORT_W + n];
                w[DW - 2 - h*HALF_W - 2*n] = e.fall[(base + h) * PORT_W + n];
            end
        return w;
    endfunction

    function automatic edge_cfg_t edge_merge(input edge_cfg_t e, input logic [DW-1:0] w,
                                             input int base);
        edge_cfg_t r;
        r = e;
        for (int h = 0; h < 2; h++)
            for (int n = 0; n < PORT_W; n++) begin
                r.rise[(base + h) * PORT_W + n] = w[DW - 1 - h*HALF_W - 2*n];
                r.fall[(base + h) * PORT_W + n] = w[DW - 2 - h*HALF_W - 2*n];
            end
        return r;
    endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NPIN-1:0] pin_lvl,
    input  logic [NPIN-1:0] stat,
    output gpio_cfg_t       cfg,
    output logic [NPIN-1:0] clr,
    output logic [DW-1:0]   rdata
);
    word_idx_t       widx;
    logic            unused_lsb;
    logic [NPIN-1:0] wpins;

    assign widx       = word_idx_t'(addr[AW-1:2]);
    assign unused_lsb = ^addr[1:0];
    assign wpins      = swizzle(wdata);
    assign clr        = (wr && widx == W_STAT) ? wpins : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (widx)
                W_FUNC:  cfg.func <= wpins;
                W_ALT:   cfg.alt  <= wpins;
                W_DIR:   cfg.dir  <= wpins;
                W_DATA:  cfg.dout <= wpins;
                W_EDGAB: cfg.edg  <= edge_merge(cfg.edg, wdata, 0);
                W_EDGCD: cfg.edg  <= edge_merge(cfg.edg, wdata, 2);
                W_IEN0:  cfg.ien0 <= wpins;
                W_IEN1:  cfg.ien1 <= wpins;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (widx)
            W_FUNC:  rdata = swizzle(cfg.func);
            W_ALT:   rdata = swizzle(cfg.alt);
            W_DIR:   rdata = swizzle(cfg.dir);
            W_DATA:  rdata = swizzle(pin_lvl);
            W_STAT:  rdata = swizzle(stat);
            W_EDGAB: rdata = edge_pack(cfg.edg, 0);
            W_EDGCD: rdata = edge_pack(cfg.edg, 2);
            W_IEN0:  rdata = swizzle(cfg.ien0);
            W_IEN1:  rdata = swizzle(cfg.ien1);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] arm,
    input  edge_cfg_t       edg,
    output logic [NPIN-1:0] lvl,
    output logic [NPIN-1:0] evt
);
    logic [NPIN-1:0] sync_q [SYNC_STAGES];
    logic [NPIN-1:0] prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)         sync_q[s] <= '0;
                else if (s == 0) sync_q[s] <= pad_in;
                else             sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign lvl = sync_q[SYNC_STAGES-1];
    assign evt = arm & ((lvl & ~prev_q & edg.rise) | (~lvl & prev_q & edg.fall));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] evt,
    input  logic [NPIN-1:0] clr,
    input  logic [NPIN-1:0] ien0,
    input  logic [NPIN-1:0] ien1,
    output logic [NPIN-1:0] stat,
    output logic            irq0,
    output logic            irq1
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | evt;
    end

    assign irq0 = |(stat & ien0);
    assign irq1 = |(stat & ien1);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] gpio_sel,
    output logic            irq_core0,
    output logic            irq_core1
);
    gpio_cfg_t       cfg;
    logic [NPIN-1:0] pin_lvl;
    logic [NPIN-1:0] evt;
    logic [NPIN-1:0] clr;
    logic [NPIN-1:0] stat_q;
    logic [NPIN-1:0] arm;

    assign arm      = cfg.func & ~cfg.dir;
    assign gpio_sel = cfg.func;
    assign pad_oe   = cfg.func & cfg.dir;
    assign pad_out  = cfg.dout;

    gpio_port_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .pin_lvl(pin_lvl), .stat(stat_q), .cfg(cfg), .clr(clr), .rdata(bus_rdata)
    );

    gpio_edge_detect u_edge (
        .clk(clk), .rst(rst), .pad_in(pad_in), .arm(arm), .edg(cfg.edg),
        .lvl(pin_lvl), .evt(evt)
    );

    gpio_irq_status u_stat (
        .clk(clk), .rst(rst), .evt(evt), .clr(clr), .ien0(cfg.ien0), .ien1(cfg.ien1),
        .stat(stat_q), .irq0(irq_core0), .irq1(irq_core1)
    );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [NPIN-1:0] stat,
    input gpio_cfg_t       cfg,
    input logic            irq0,
    input logic            irq1
);
    // R1: a reset cycle leaves no status and quiet interrupt lines
    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (stat == '0 && !irq0 && !irq1));

    // R7: new status only on pins that were GPIO inputs in the detecting cycle
    p_set_only_inputs_r7: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & $past(~cfg.func | cfg.dir)) == '0));

    // R8: a status bit drops only after a write to the status word
    p_clear_by_write_r8: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat) & ~stat)) |-> $past(bus_wr && bus_addr[AW-1:2] == W_STAT));

    // R9: an interrupt line needs a pending status bit
    p_irq0_pending_r9: assert property (@(posedge clk) disable iff (rst)
        irq0 |-> (stat != '0));
    p_irq1_pending_r9: assert property (@(posedge clk) disable iff (rst)
        irq1 |-> (stat != '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .stat(stat_q), .cfg(cfg), .irq0(irq_core0), .irq1(irq_core1)
);

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, gpio_sel;
    logic        irq_core0, irq_core1;
    int          total = 0;
    int          bad = 0;
    logic [31:0] rd;

    localparam logic [7:0] A_FUNC = 8'h00, A_ALT = 8'h04, A_DIR = 8'h08, A_DATA = 8'h0C,
                           A_STAT = 8'h10, A_EAB = 8'h14, A_ECD = 8'h18,
                           A_IE0 = 8'h38, A_IE1 = 8'h3C;

    always #4 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .gpio_sel(gpio_sel), .irq_core0(irq_core0), .irq_core1(irq_core1)
    );

    // word bit for logical pin p: port*8 + 7 - pin
    function automatic logic [31:0] wbit(input int p);
        return 32'h1 << ((p / 8) * 8 + 7 - (p % 8));
    endfunction

    function automatic logic [31:0] to_word(input logic [31:0] v);
        logic [31:0] w = '0;
        for (int p = 0; p < 32; p++) if (v[p]) w |= wbit(p);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdw(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] addrs [9] = '{A_FUNC, A_ALT, A_DIR, A_DATA, A_STAT, A_EAB, A_ECD, A_IE0, A_IE1};
        foreach (addrs[i]) begin
            rdw(addrs[i], rd);
            chk("R1 register zero after reset", rd, 32'h0);
        end
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 gpio_sel", gpio_sel, 32'h0);
        chk("R1 irqs", {30'h0, irq_core1, irq_core0}, 32'h0);
    endtask

    task automatic t_layout;
        wr(A_FUNC, 32'h0000_0080);
        chk("R2 word bit 7 is pin A0", gpio_sel, 32'h0000_0001);
        wr(A_FUNC, 32'h0100_0000);
        chk("R2 word bit 24 is pin D7", gpio_sel, 32'h8000_0000);
        rdw(A_FUNC, rd);
        chk("R2 function readback", rd, 32'h0100_0000);
        wr(A_FUNC, 32'h0);
    endtask

    task automatic t_output;
        wr(A_FUNC, 32'hFFFF_FFFF);
        wr(A_DIR, to_word(32'h0000_0F00));
        wr(A_DATA, to_word(32'h8000_0A01));
        chk("R4 pad_oe from direction", pad_oe, 32'h0000_0F00);
        chk("R4 pad_out from data", pad_out, 32'h8000_0A01);
        wr(A_FUNC, 32'h0);
        chk("R3 alternate pins release oe", pad_oe, 32'h0);
        chk("R3 gpio_sel cleared", gpio_sel, 32'h0);
        wr(A_DIR, 32'h0);
    endtask

    task automatic t_sample;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk);
        #1 bus_addr = A_DATA;
        #1 chk("R5 not visible after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1 chk("R5 visible after two edges", bus_rdata, to_word(32'h1234_5678));
        @(negedge clk);
        pad_in = 32'h0;
        idle(4);
    endtask

    // drive pad bit p to v, return status word on the 2nd and 3rd following sample points
    task automatic edge_probe(input int p, input logic v, output logic [31:0] s2,
                              output logic [31:0] s3);
        @(negedge clk);
        pad_in[p] = v;
        bus_addr = A_STAT;
        @(negedge clk);
        @(negedge clk);
        #1 s2 = bus_rdata;
        @(negedge clk);
        #1 s3 = bus_rdata;
        idle(2);
    endtask

    task automatic t_edges;
        logic [31:0] s2, s3;
        wr(A_FUNC, 32'hFFFF_FFFF);
        wr(A_EAB, 32'h1 << 13);           // port B pin1 rise
        rdw(A_EAB, rd);
        chk("R6 edge AB readback", rd, 32'h0000_2000);
        edge_probe(9, 1'b1, s2, s3);
        chk("R7 status not before third edge", s2, 32'h0);
        chk("R7 rise on B1 sets word bit 14", s3, 32'h0000_4000);
        wr(A_STAT, 32'h0);
        rdw(A_STAT, rd);
        chk("R8 write zero keeps status", rd, 32'h0000_4000);
        wr(A_STAT, 32'h0000_4000);
        rdw(A_STAT, rd);
        chk("R8 write one clears status", rd, 32'h0);
        edge_probe(9, 1'b0, s2, s3);
        chk("R7 fall ignored when only rise selected", s3, 32'h0);
        // port D pin2 both edges (bits 11,10), port C pin0 fall only (bit 30)
        wr(A_ECD, (32'h1 << 30) | (32'h3 << 10));
        edge_probe(26, 1'b1, s2, s3);
        chk("R6 R7 rise on D2 with both selected", s3, 32'h2000_0000);
        wr(A_STAT, 32'hFFFF_FFFF);
        edge_probe(26, 1'b0, s2, s3);
        chk("R7 fall on D2 with both selected", s3, 32'h2000_0000);
        wr(A_STAT, 32'hFFFF_FFFF);
        edge_probe(16, 1'b1, s2, s3);
        chk("R7 rise ignored on fall-only C0", s3, 32'h0);
        edge_probe(16, 1'b0, s2, s3);
        chk("R6 R7 fall on C0 sets word bit 23", s3, 32'h0080_0000);
        wr(A_STAT, 32'hFFFF_FFFF);
        // output pin and alternate-function pin
        wr(A_DIR, wbit(26));
        edge_probe(26, 1'b1, s2, s3);
        chk("R7 output pin sets no status", s3, 32'h0);
        wr(A_FUNC, 32'hFFFF_FFFF & ~wbit(9));
        edge_probe(9, 1'b1, s2, s3);
        chk("R7 alternate pin sets no status", s3, 32'h0);
        wr(A_DIR, 32'h0);
        wr(A_FUNC, 32'hFFFF_FFFF);
        edge_probe(9, 1'b0, s2, s3);
        edge_probe(26, 1'b0, s2, s3);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq;
        logic [31:0] s2, s3;
        edge_probe(9, 1'b1, s2, s3);
        chk("R9 status latches with enables off", s3, 32'h0000_4000);
        chk("R9 no irq with enables off", {30'h0, irq_core1, irq_core0}, 32'h0);
        wr(A_IE0, 32'h0000_4000);
        chk("R9 core0 irq raised", {31'h0, irq_core0}, 32'h1);
        chk("R9 core1 stays low", {31'h0, irq_core1}, 32'h0);
        wr(A_IE1, 32'h0000_2000);
        chk("R9 core1 enable on other pin", {31'h0, irq_core1}, 32'h0);
        wr(A_IE1, 32'h0000_4000);
        chk("R9 core1 irq raised", {31'h0, irq_core1}, 32'h1);
        wr(A_STAT, 32'h0000_4000);
        chk("R8 R9 clear drops both irqs", {30'h0, irq_core1, irq_core0}, 32'h0);
        wr(A_EAB, 32'h0);
        wr(A_ECD, 32'h0);
        @(negedge clk);
        pad_in = 32'h0;
        idle(4);
    endtask

    task automatic t_alt;
        logic [31:0] oe0, sel0, out0;
        oe0 = pad_oe; sel0 = gpio_sel; out0 = pad_out;
        wr(A_ALT, 32'hDEAD_BEEF);
        rdw(A_ALT, rd);
        chk("R10 alternate-select readback", rd, 32'hDEAD_BEEF);
        chk("R10 alternate-select no effect on outputs",
            (pad_oe ^ oe0) | (gpio_sel ^ sel0) | (pad_out ^ out0), 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rdw(8'h20, rd);
        chk("R10 unmapped reads zero", rd, 32'h0);
        rdw(A_FUNC, rd);
        chk("R10 unmapped write ignored", rd, 32'hFFFF_FFFF);
        rdw(A_DIR, rd);
        chk("R10 unmapped write leaves direction", rd, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_layout();
        t_output();
        t_sample();
        t_edges();
        t_irq();
        t_alt();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule